// File: doc/BRIEF.md
# Oversampling ADC Result Accumulator Register

This block holds the result of one converter channel. Each conversion-done strobe brings a 12-bit sample. Depending on a mode bit, the sample either replaces the stored 18-bit value or is added to it. This lets software average several conversions without handling each one. A conversion counter raises a sticky completion interrupt once a programmed number of samples has arrived. A read-only flag inverts on every accepted conversion, so software can spot conversions it did not see.

Software reaches the control word through a small register-bus write port. The port has four aliases: plain write, bit set, bit clear and bit invert. The whole word is always visible on a combinational read port. The running sum is never cleared by hardware. Software writes zero to the value field before it starts a multi-sample sum, and it divides the result itself.

Top module: `adc_result_accum`

## Requirements
- R1: After reset, `rd_data` reads 0 and `irq` is 0.
- R2: Word layout: bit 31 is the conversion flag, bit 29 is accumulate-enable, bits 28:24 are the sample count and bits 17:0 are the value. Bit 30 and bits 23:18 always read 0 and ignore every write.
- R3: Write offsets: `wr_addr` 0x0 loads the word, 0x4 sets the bits that are 1 in `wr_data`, 0x8 clears those bits and 0xC inverts them. A write to any other offset has no effect.
- R4: With accumulate-enable at 0, an accepted conversion replaces the value field with the zero-extended sample.
- R5: With accumulate-enable at 1, an accepted conversion adds the sample to the value field, modulo 2^18. Hardware never clears the field.
- R6: Bit 31 inverts on every accepted conversion and on nothing else. No bus write can change it.
- R7: Each accepted conversion advances a counter. When the counter reaches the sample count (1 if the count is 0), `irq` is set on the next cycle and the counter restarts. Any accepted bus write also restarts the counter.
- R8: `irq` stays at 1 until an `irq_ack` cycle clears it. If a completion and `irq_ack` fall in the same cycle, the completion wins.
- R9: If an accepted bus write and `conv_done` fall in the same cycle, the write takes effect and the sample is dropped. The value, bit 31 and the counter are then untouched by the sample.
- R10: A sum of 32 full-scale samples (0xFFF each) reads exactly 0x1FFE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Byte offset that selects the alias |
| wr_data | input | 32 | Bus write data |
| rd_data | output | 32 | Current control and result word |
| conv_done | input | 1 | Conversion-done strobe, one cycle per sample |
| conv_sample | input | 12 | Converter result that goes with `conv_done` |
| irq_ack | input | 1 | Clears the completion interrupt |
| irq | output | 1 | Sticky completion interrupt |

## Verification
All state is registered, and `rd_data` is decoded combinationally from those registers. A write, an accepted sample and an acknowledge therefore all show on `rd_data` and `irq` one rising edge after the cycle that presents them; none takes longer. The bench drives every input at the falling edge and lets one rising edge pass. It then samples 1 ns later and compares both outputs with a reference model that it has advanced by exactly that one edge. Each stimulus cycle is therefore checked in the cycle its results are due, never earlier and never a cycle late.

// File: rtl/adc_accum_pkg.sv
`timescale 1ns/1ps
package adc_accum_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SMP_W   = 12;
    localparam int unsigned SUM_W   = 18;
    localparam int unsigned CNT_W   = 5;
    localparam int unsigned FLAG_POS = 31;
    localparam int unsigned ACC_POS  = 29;
    localparam int unsigned CNT_POS  = 24;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_INVERT = 2'd3
    } wr_op_e;

    typedef struct packed {
        logic             acc_en;
        logic [CNT_W-1:0] n_smp;
        logic [SUM_W-1:0] sum;
    } cfg_t;
endpackage

// File: rtl/accum_bus_decode.sv
`timescale 1ns/1ps
module accum_bus_decode
    import adc_accum_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  cfg_t              cur_cfg,
    output logic              hit,
    output cfg_t              nxt_cfg
);
    logic          hi_zero;
    wr_op_e        op;
    logic [WORD_W-1:0] cur_w;
    logic [WORD_W-1:0] new_w;

    generate
        if (ADDR_W > 4) begin : g_hi
            assign hi_zero = (wr_addr[ADDR_W-1:4] == '0);
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    assign op  = wr_op_e'(wr_addr[3:2]);
    assign hit = wr_en && hi_zero && (wr_addr[1:0] == 2'b00);

    always_comb begin
        cur_w = '0;
        cur_w[ACC_POS]             = cur_cfg.acc_en;
        cur_w[CNT_POS +: CNT_W]    = cur_cfg.n_smp;
        cur_w[SUM_W-1:0]           = cur_cfg.sum;
        unique case (op)
            OP_LOAD:   new_w = wr_data;
            OP_SET:    new_w = cur_w | wr_data;
            OP_CLEAR:  new_w = cur_w & ~wr_data;
            default:   new_w = cur_w ^ wr_data;
        endcase
        nxt_cfg.acc_en = new_w[ACC_POS];
        nxt_cfg.n_smp  = new_w[CNT_POS +: CNT_W];
        nxt_cfg.sum    = new_w[SUM_W-1:0];
    end
endmodule

// File: rtl/accum_value_path.sv
`timescale 1ns/1ps
module accum_value_path
    import adc_accum_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_hit,
    input  cfg_t             bus_cfg,
    input  logic             conv_ok,
    input  logic [SMP_W-1:0] sample,
    output cfg_t             cfg,
    output logic             flag
);
    typedef struct packed {
        cfg_t cfg;
        logic flag;
    } vstate_t;

    localparam int unsigned PAD_W = SUM_W - SMP_W;

    vstate_t          st_d, st_q;
    logic [SUM_W-1:0] smp_ext;

    assign smp_ext = {{PAD_W{1'b0}}, sample};

    always_comb begin
        st_d = st_q;
        if (bus_hit) begin
            st_d.cfg = bus_cfg;
        end else if (conv_ok) begin
            st_d.flag = ~st_q.flag;
            if (st_q.cfg.acc_en) begin
                st_d.cfg.sum = st_q.cfg.sum + smp_ext;
            end else begin
                st_d.cfg.sum = smp_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg  = st_q.cfg;
    assign flag = st_q.flag;

    // R4
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_ok && !bus_hit && !st_q.cfg.acc_en) |=> (st_q.cfg.sum == $past(smp_ext)));

    // R6
    flag_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_ok && !bus_hit) |=> (st_q.flag != $past(st_q.flag)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_ok && !bus_hit) |=> $stable(st_q.flag));
endmodule

// File: rtl/accum_sample_counter.sv
`timescale 1ns/1ps
module accum_sample_counter
    import adc_accum_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             conv_ok,
    input  logic [CNT_W-1:0] n_smp,
    input  logic             irq_ack,
    output logic             irq
);
    localparam int unsigned EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cstate_t;

    cstate_t          st_d, st_q;
    logic [EXT_W-1:0] target;
    logic [EXT_W-1:0] cnt_inc;
    logic             done;

    assign target  = (n_smp == '0) ? EXT_W'(1) : {1'b0, n_smp};
    assign cnt_inc = {1'b0, st_q.cnt} + EXT_W'(1);

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (conv_ok) begin
            if (cnt_inc >= target) begin
                st_d.cnt = '0;
                done     = 1'b1;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
        if (done)         st_d.irq = 1'b1;
        else if (irq_ack) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.cnt} < target));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_ack) |=> st_q.irq);

    // R8
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !conv_ok) |=> !st_q.irq);
endmodule

// File: rtl/adc_result_accum.sv
`timescale 1ns/1ps
module adc_result_accum
    import adc_accum_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              conv_done,
    input  logic [11:0]       conv_sample,
    input  logic              irq_ack,
    output logic              irq
);
    logic hit;
    logic conv_ok;
    logic flag;
    cfg_t bus_cfg;
    cfg_t cfg;

    accum_bus_decode #(.ADDR_W(ADDR_W)) i_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur_cfg (cfg),
        .hit     (hit),
        .nxt_cfg (bus_cfg)
    );

    assign conv_ok = conv_done && !hit;

    accum_value_path i_value (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_hit (hit),
        .bus_cfg (bus_cfg),
        .conv_ok (conv_ok),
        .sample  (conv_sample),
        .cfg     (cfg),
        .flag    (flag)
    );

    accum_sample_counter i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hit),
        .conv_ok (conv_ok),
        .n_smp   (cfg.n_smp),
        .irq_ack (irq_ack),
        .irq     (irq)
    );

    always_comb begin
        rd_data = '0;
        rd_data[FLAG_POS]          = flag;
        rd_data[ACC_POS]           = cfg.acc_en;
        rd_data[CNT_POS +: CNT_W]  = cfg.n_smp;
        rd_data[SUM_W-1:0]         = cfg.sum;
    end

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (rd_data[SUM_W-1:0] == $past(wr_data[SUM_W-1:0])));
endmodule

// File: tb/test_adc_result_accum.sv
`timescale 1ns/1ps
module test_adc_result_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        conv_done = 1'b0;
    logic [11:0] conv_sample = '0;
    logic        irq_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    logic        m_flag = 1'b0;
    logic        m_acc = 1'b0;
    logic [4:0]  m_n = '0;
    logic [17:0] m_val = '0;
    int          m_cnt = 0;
    logic        m_irq = 1'b0;

    always #2 clk = ~clk;

    adc_result_accum i_adc_result_accum (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(rd_data), .conv_done(conv_done),
        .conv_sample(conv_sample), .irq_ack(irq_ack), .irq(irq)
    );

    function automatic logic [31:0] exp_word();
        return {m_flag, 1'b0, m_acc, m_n, 6'b0, m_val};
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic wr, input logic [3:0] a, input logic [31:0] d,
                         input logic cv, input logic [11:0] s, input logic ak);
        logic [31:0] w;
        logic        hitm;
        logic        fin;
        fin  = 1'b0;
        hitm = wr && (a == 4'h0 || a == 4'h4 || a == 4'h8 || a == 4'hC);
        if (hitm) begin
            w = {2'b0, m_acc, m_n, 6'b0, m_val};
            case (a)
                4'h0:    w = d;
                4'h4:    w = w | d;
                4'h8:    w = w & ~d;
                default: w = w ^ d;
            endcase
            m_acc = w[29];
            m_n   = w[28:24];
            m_val = w[17:0];
            m_cnt = 0;
        end else if (cv) begin
            m_flag = ~m_flag;
            m_val  = m_acc ? (m_val + {6'b0, s}) : {6'b0, s};
            if (m_cnt + 1 >= ((m_n == 0) ? 1 : int'(m_n))) begin
                m_cnt = 0;
                fin   = 1'b1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (fin)     m_irq = 1'b1;
        else if (ak) m_irq = 1'b0;
    endtask

    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic cv, input logic [11:0] s, input logic ak, input string tag);
        @(negedge clk);
        wr_en = wr; wr_addr = a; wr_data = d;
        conv_done = cv; conv_sample = s; irq_ack = ak;
        @(posedge clk);
        model(wr, a, d, cv, s, ak);
        #1;
        check32({tag, " word"}, rd_data, exp_word());
        check32({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check32("R1 reset word", rd_data, 32'h0);
        check32("R1 reset irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;

        // R2: reserved bits and the flag bit ignore a full load
        step(1, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, "R2 layout");
        // R3: aliases
        step(1, 4'h8, 32'hFFFF_FFFF, 0, 0, 0, "R3 clear");
        step(1, 4'h4, 32'h2000_0000, 0, 0, 0, "R3 set");
        step(1, 4'hC, 32'h0100_0000, 0, 0, 0, "R3 invert");
        step(1, 4'h2, 32'hFFFF_FFFF, 0, 0, 0, "R3 bad offset");
        step(1, 4'h5, 32'h0000_1234, 0, 0, 0, "R3 bad offset");
        // R6: flag bit cannot be written
        step(1, 4'hC, 32'h8000_0000, 0, 0, 0, "R6 flag write");
        step(1, 4'h4, 32'h8000_0000, 0, 0, 0, "R6 flag write");

        // R4 / R7: overwrite with count 0 -> irq on every conversion
        step(1, 4'h0, 32'h0, 0, 0, 0, "R4 setup");
        step(0, 0, 0, 1, 12'h123, 0, "R4 R7 replace");
        step(0, 0, 0, 1, 12'hABC, 0, "R4 R6 replace");
        // R8
        step(0, 0, 0, 0, 0, 0, "R8 sticky");
        step(0, 0, 0, 0, 0, 1, "R8 ack");
        step(0, 0, 0, 1, 12'h001, 1, "R8 ack vs completion");
        step(0, 0, 0, 0, 0, 1, "R8 ack");

        // R5 / R7: accumulate five samples
        step(1, 4'h0, 32'h2500_0000, 0, 0, 0, "R5 setup");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 12'd100, 0, "R5 R7 accumulate");
        step(0, 0, 0, 1, 12'd7, 0, "R5 no auto clear");
        // R9: collision drops the sample
        step(1, 4'h4, 32'h0, 1, 12'hFFF, 0, "R9 collision");
        step(1, 4'h0, 32'h2000_0055, 1, 12'hFFF, 0, "R9 collision load");
        step(1, 4'h7, 32'h0, 1, 12'h010, 0, "R9 bad offset keeps sample");

        // R10: 32 full-scale samples
        step(1, 4'h0, 32'h2000_0000, 0, 0, 1, "R10 setup");
        for (int i = 0; i < 32; i++) step(0, 0, 0, 1, 12'hFFF, 0, "R10 full scale");
        check32("R10 sum", {14'b0, rd_data[17:0]}, 32'h0001_FFE0);

        // random mix over R3..R9
        for (int i = 0; i < 3000; i++) begin
            logic        wr, cv, ak;
            logic [3:0]  a;
            logic [31:0] d;
            wr = ($urandom % 8) == 0;
            cv = ($urandom % 2) == 0;
            ak = ($urandom % 6) == 0;
            case ($urandom % 6)
                0: a = 4'h0; 1: a = 4'h4; 2: a = 4'h8; 3: a = 4'hC;
                4: a = 4'h1; default: a = 4'h6;
            endcase
            d = $urandom;
            d[4:0] = ($urandom % 2) ? 5'h0 : d[4:0];
            step(wr, a, d, cv, 12'($urandom), ak, "R3 R5 R7 R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule